// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block holds the match logic for two independent time-of-day alarms. Each alarm has six stored fields: second, minute, hour, date, month and day of week. Each field is compared against the matching live calendar byte.

The top bit of every alarm field is that field's enable. Only enabled fields take part in the comparison, and the year is never compared. The comparison is taken on the one-second strobe, which arrives after the calendar has advanced. A sticky status flag is raised when the comparison result goes from false to true, so an alarm fires again each time its pattern recurs.

A status read clears the flags. It is framed by a start strobe and an end strobe. The end strobe clears only the flags that were already set when the start strobe arrived.

One shared output pin serves two purposes. It can be an active-low interrupt, formed from the flags whose interrupt enable is set. It can instead pass through one of three reference clocks, chosen by a two-bit select.

Top module: `alm_dual`

## Requirements
- R1: Byte f of an alarm (0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week) uses bit 7 as its enable. An enabled field matches when bits 6:0 equal bits 6:0 of time byte f. Bit 7 of the time byte is ignored, and disabled fields do not take part.
- R2: An alarm with no field enabled never fires.
- R3: An alarm fires only in a cycle where `tick` is 1 and all of its enabled fields match, while the previous tick found no match. A match that persists across ticks does not fire again. A match that goes away and returns fires again.
- R4: A firing sets that alarm's bit in `al_flag` (bit 0 for alarm 0, bit 1 for alarm 1) at the same clock edge that samples `tick`. The bit then stays set until a status read clears it.
- R5: `rd_start` records the flags that are set at that edge. `rd_end` clears only those recorded flags. A flag that fires after the start, or in the same cycle as `rd_end`, remains set.
- R6: An `rd_end` with no `rd_start` since the last `rd_end` or since reset clears nothing.
- R7: The two alarms are independent. A match on one alarm never sets the other alarm's flag.
- R8: When `freq_sel` is 00, `irq_fout_n` is 0 if any flag bit is set together with the same bit of `irq_en`, and 1 otherwise.
- R9: When `freq_sel` is 01, `irq_fout_n` follows `ref_1hz`. When it is 10, the pin follows `ref_4khz`. When it is 11, the pin follows `ref_32khz`.
- R10: While `rst_n` is low, and after it is released, `al_flag` is 0, and `irq_fout_n` is 1 when `freq_sel` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe, arriving after the calendar increment |
| time_now | input | 48 | Live calendar; byte f at bits 8f+7:8f |
| alarm_regs | input | 96 | Alarm a, field f at bits 8(6a+f)+7 : 8(6a+f) |
| irq_en | input | 2 | Per-alarm interrupt enable |
| freq_sel | input | 2 | Pin mode: 00 interrupt, 01/10/11 reference clock |
| ref_1hz | input | 1 | 1 Hz reference level |
| ref_4khz | input | 1 | 4096 Hz reference level |
| ref_32khz | input | 1 | 32768 Hz reference level |
| rd_start | input | 1 | Status read begins (one-cycle strobe) |
| rd_end | input | 1 | Status read ends (one-cycle strobe) |
| al_flag | output | 2 | Sticky alarm flags |
| irq_fout_n | output | 1 | Shared interrupt or frequency pin |

## Verification
The delicate collision is between an alarm firing and the status-read handshake. A new firing can land after `rd_start`, or in the very cycle that carries `rd_end`. In either case, the set must win over the clear for that flag, while the flags recorded at the start still drop.

The bench produces both cases. It toggles a calendar field between ticks so that a fresh rising match coincides with an open read, or with the end strobe itself. It then judges the flag vector on the following cycle against a behavioural model that tracks every clock.

// File: rtl/alm_pkg.sv
package alm_pkg;
   typedef enum logic [1:0] {
      PIN_IRQ   = 2'd0,
      PIN_1HZ   = 2'd1,
      PIN_4KHZ  = 2'd2,
      PIN_32KHZ = 2'd3
   } pin_mode_e;
endpackage

// File: rtl/alm_unit.sv
module alm_unit #(
   parameter int NF = 6,
   parameter int FW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [NF*FW-1:0] now,
   input  logic [NF*FW-1:0] cfg,
   output logic             fire
);
   localparam int VW = FW - 1;

   logic [NF-1:0] fld_en;
   logic [NF-1:0] fld_ok;
   logic          match;
   logic          prev_match;

   for (genvar f = 0; f < NF; f++) begin : g_fld
      assign fld_en[f] = cfg[f*FW + VW];
      assign fld_ok[f] = !fld_en[f] || (cfg[f*FW +: VW] == now[f*FW +: VW]);
   end

   assign match = (|fld_en) && (&fld_ok);
   assign fire  = tick && match && !prev_match;

   always_ff @(posedge clk) begin
      if (!rst_n)    prev_match <= 1'b0;
      else if (tick) prev_match <= match;
   end
endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
   parameter int NA = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NA-1:0] fire,
   input  logic          rd_start,
   input  logic          rd_end,
   output logic [NA-1:0] flags
);
   logic [NA-1:0] snap;
   logic [NA-1:0] clr;

   assign clr = rd_end ? snap : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         snap  <= '0;
      end else begin
         flags <= (flags & ~clr) | fire;
         if (rd_start)    snap <= flags;
         else if (rd_end) snap <= '0;
      end
   end
endmodule

// File: rtl/alm_pin.sv
module alm_pin #(
   parameter int NA = 2
) (
   input  logic [NA-1:0] flags,
   input  logic [NA-1:0] irq_en,
   input  logic [1:0]    freq_sel,
   input  logic          ref_1hz,
   input  logic          ref_4khz,
   input  logic          ref_32khz,
   output logic          pin_n
);
   import alm_pkg::*;

   pin_mode_e mode;
   assign mode = pin_mode_e'(freq_sel);

   always_comb begin
      unique case (mode)
         PIN_IRQ:   pin_n = ~|(flags & irq_en);
         PIN_1HZ:   pin_n = ref_1hz;
         PIN_4KHZ:  pin_n = ref_4khz;
         PIN_32KHZ: pin_n = ref_32khz;
         default:   pin_n = 1'b1;
      endcase
   end
endmodule

// File: rtl/alm_dual.sv
module alm_dual #(
   parameter int NA = 2,
   parameter int NF = 6,
   parameter int FW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [NF*FW-1:0]    time_now,
   input  logic [NA*NF*FW-1:0] alarm_regs,
   input  logic [NA-1:0]       irq_en,
   input  logic [1:0]          freq_sel,
   input  logic                ref_1hz,
   input  logic                ref_4khz,
   input  logic                ref_32khz,
   input  logic                rd_start,
   input  logic                rd_end,
   output logic [NA-1:0]       al_flag,
   output logic                irq_fout_n
);
   localparam int AW = NF * FW;

   if (FW < 2) begin : g_bad_fw
      $error("alm_dual: FW must leave room for an enable bit");
   end
   if (NA < 1 || NF < 1) begin : g_bad_cnt
      $error("alm_dual: NA and NF must be positive");
   end

   logic [NA-1:0] fire;

   for (genvar a = 0; a < NA; a++) begin : g_alm
      alm_unit #(.NF(NF), .FW(FW)) u_unit (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .now  (time_now),
         .cfg  (alarm_regs[a*AW +: AW]),
         .fire (fire[a])
      );
   end

   alm_flags #(.NA(NA)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .rd_start(rd_start),
      .rd_end  (rd_end),
      .flags   (al_flag)
   );

   alm_pin #(.NA(NA)) u_pin (
      .flags    (al_flag),
      .irq_en   (irq_en),
      .freq_sel (freq_sel),
      .ref_1hz  (ref_1hz),
      .ref_4khz (ref_4khz),
      .ref_32khz(ref_32khz),
      .pin_n    (irq_fout_n)
   );
endmodule

// File: rtl/alm_dual_chk.sv
module alm_dual_chk #(
   parameter int NA = 2,
   parameter int NF = 6,
   parameter int FW = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic [NF*FW-1:0]    time_now,
   input logic [NA*NF*FW-1:0] alarm_regs,
   input logic [NA-1:0]       irq_en,
   input logic [1:0]          freq_sel,
   input logic                ref_1hz,
   input logic                ref_4khz,
   input logic                ref_32khz,
   input logic                rd_start,
   input logic                rd_end,
   input logic [NA-1:0]       al_flag,
   input logic                irq_fout_n
);
   logic [NA-1:0] any_en;

   always_comb begin
      for (int a = 0; a < NA; a++) begin
         any_en[a] = 1'b0;
         for (int f = 0; f < NF; f++)
            any_en[a] = any_en[a] | alarm_regs[(a*NF + f)*FW + FW - 1];
      end
   end

   for (genvar a = 0; a < NA; a++) begin : g_chk
      AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(al_flag[a]) |-> $past(tick)); // R3
      AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(al_flag[a]) |-> $past(any_en[a])); // R2
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (al_flag[a] && !rd_end) |=> al_flag[a]); // R4
      AST_CLEAR_BY_END: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(al_flag[a]) |-> $past(rd_end)); // R5
   end

   AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_sel == 2'b00 && (al_flag & irq_en) == '0) |-> irq_fout_n); // R8
endmodule

bind alm_dual alm_dual_chk #(.NA(NA), .NF(NF), .FW(FW)) u_chk (.*);

// File: tb/alm_dual_test.sv
`timescale 1ns/1ps
module alm_dual_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [47:0] time_now = '0;
   logic [95:0] alarm_regs = '0;
   logic [1:0]  irq_en = 2'b00;
   logic [1:0]  freq_sel = 2'b00;
   logic        ref_1hz = 1'b0, ref_4khz = 1'b0, ref_32khz = 1'b0;
   logic        rd_start = 1'b0, rd_end = 1'b0;
   logic [1:0]  al_flag;
   logic        irq_fout_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   alm_dual uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .time_now(time_now),
      .alarm_regs(alarm_regs), .irq_en(irq_en), .freq_sel(freq_sel),
      .ref_1hz(ref_1hz), .ref_4khz(ref_4khz), .ref_32khz(ref_32khz),
      .rd_start(rd_start), .rd_end(rd_end),
      .al_flag(al_flag), .irq_fout_n(irq_fout_n)
   );

   // behavioural reference
   bit m_prev[2];
   bit m_flag[2];
   bit m_snap[2];

   function automatic bit ref_match(int a);
      int  n = 0;
      bit  ok = 1'b1;
      for (int f = 0; f < 6; f++) begin
         logic [7:0] v = alarm_regs[(a*6 + f)*8 +: 8];
         logic [7:0] t = time_now[f*8 +: 8];
         if (v[7]) begin
            n++;
            if (v[6:0] != t[6:0]) ok = 1'b0;
         end
      end
      return (n > 0) && ok;
   endfunction

   always @(posedge clk) begin
      bit fire[2];
      bit old[2];
      for (int a = 0; a < 2; a++) begin
         fire[a] = tick && ref_match(a) && !m_prev[a];
         old[a]  = m_flag[a];
      end
      if (!rst_n) begin
         for (int a = 0; a < 2; a++) begin
            m_prev[a] = 0; m_flag[a] = 0; m_snap[a] = 0;
         end
      end else begin
         for (int a = 0; a < 2; a++) begin
            if (tick) m_prev[a] = ref_match(a);
            if (rd_end && m_snap[a]) m_flag[a] = 0;
            if (fire[a]) m_flag[a] = 1;
            if (rd_start)    m_snap[a] = old[a];
            else if (rd_end) m_snap[a] = 0;
         end
      end
   end

   function automatic logic model_pin();
      case (freq_sel)
         2'b00: return !((m_flag[0] && irq_en[0]) || (m_flag[1] && irq_en[1]));
         2'b01: return ref_1hz;
         2'b10: return ref_4khz;
         default: return ref_32khz;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: after the edge, compare against the model
   task automatic step();
      @(posedge clk);
      #1;
      check({30'd0, al_flag}, {30'd0, m_flag[1], m_flag[0]}, "R4 model flags");
      check({31'd0, irq_fout_n}, {31'd0, model_pin()}, "R8 model pin");
   endtask

   task automatic pulse_tick();
      tick = 1'b1; step(); tick = 1'b0;
   endtask

   task automatic pulse_start();
      rd_start = 1'b1; step(); rd_start = 1'b0;
   endtask

   task automatic pulse_end();
      rd_end = 1'b1; step(); rd_end = 1'b0;
   endtask

   task automatic set_tf(int f, logic [7:0] v);
      time_now[f*8 +: 8] = v;
   endtask

   task automatic set_af(int a, int f, logic [7:0] v);
      alarm_regs[(a*6 + f)*8 +: 8] = v;
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      check({30'd0, al_flag}, 32'd0, "R10 flags in reset");
      check({31'd0, irq_fout_n}, 32'd1, "R10 pin in reset");
      rst_n = 1'b1;
      step();
      check({30'd0, al_flag}, 32'd0, "R10 flags after reset");

      // calendar and alarms
      set_tf(0, 8'h30); set_tf(1, 8'h12); set_tf(2, 8'h08);
      set_tf(3, 8'h15); set_tf(4, 8'h06); set_tf(5, 8'h03);
      set_af(0, 0, 8'hB0);                       // alarm 0: second 30 only
      for (int f = 0; f < 6; f++) set_af(1, f, time_now[f*8 +: 8]); // alarm 1 equal but disabled
      step();
      check({30'd0, al_flag}, 32'd0, "R3 no fire without tick");

      pulse_tick();
      check({30'd0, al_flag}, 32'd1, "R1 second-only match sets flag0");
      check({31'd0, al_flag[1]}, 32'd0, "R2 all-disabled alarm silent");
      check({31'd0, al_flag[1]}, 32'd0, "R7 alarm1 untouched by alarm0");
      repeat (3) step();
      check({30'd0, al_flag}, 32'd1, "R4 flag sticky");

      pulse_start(); step(); pulse_end();
      check({30'd0, al_flag}, 32'd0, "R5 read clears flag");

      pulse_tick();
      check({30'd0, al_flag}, 32'd0, "R3 persistent match no refire");
      set_tf(0, 8'h31); pulse_tick();
      set_tf(0, 8'h30); pulse_tick();
      check({30'd0, al_flag}, 32'd1, "R3 returning match refires");

      // alarm 1 on hour, time byte bit7 set
      for (int f = 0; f < 6; f++) set_af(1, f, 8'h00);
      set_af(1, 2, 8'h95);
      set_tf(2, 8'h95);
      pulse_tick();
      check({30'd0, al_flag}, 32'd3, "R1 hour match ignores time bit7");

      pulse_start(); pulse_end();
      check({30'd0, al_flag}, 32'd0, "R5 both cleared");

      set_tf(2, 8'h96); set_tf(0, 8'h31); pulse_tick();
      set_tf(0, 8'h30); pulse_tick();
      check({30'd0, al_flag}, 32'd1, "R7 only alarm0 fires");
      pulse_start();
      set_tf(2, 8'h95); pulse_tick();
      check({30'd0, al_flag}, 32'd3, "R5 fire during read");
      pulse_end();
      check({30'd0, al_flag}, 32'd2, "R5 late flag survives read");

      pulse_end();
      check({30'd0, al_flag}, 32'd2, "R6 lone end clears nothing");

      set_tf(0, 8'h31); pulse_tick();
      pulse_start();
      set_tf(0, 8'h30);
      tick = 1'b1; rd_end = 1'b1; step(); tick = 1'b0; rd_end = 1'b0;
      check({30'd0, al_flag}, 32'd1, "R5 fire with end strobe kept");

      irq_en = 2'b01; step();
      check({31'd0, irq_fout_n}, 32'd0, "R8 enabled flag asserts pin");
      irq_en = 2'b10; step();
      check({31'd0, irq_fout_n}, 32'd1, "R8 masked flag leaves pin high");

      freq_sel = 2'b01; ref_1hz = 1'b1; step();
      check({31'd0, irq_fout_n}, 32'd1, "R9 1hz high");
      ref_1hz = 1'b0; ref_4khz = 1'b1; step();
      check({31'd0, irq_fout_n}, 32'd0, "R9 1hz low");
      freq_sel = 2'b10; step();
      check({31'd0, irq_fout_n}, 32'd1, "R9 4khz");
      freq_sel = 2'b11; ref_32khz = 1'b0; step();
      check({31'd0, irq_fout_n}, 32'd0, "R9 32khz low");
      ref_32khz = 1'b1; step();
      check({31'd0, irq_fout_n}, 32'd1, "R9 32khz high");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule